// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked on-chip request bus and an external asynchronous static RAM of 64K words by 16 bits that has one active-low enable per byte lane. A request carries a write flag, a word address, write data and a per-lane byte enable. The controller turns each request into a sequence of chip-select, write-strobe, output-enable and lane-enable levels on the memory pins. Every phase of that sequence lasts a whole number of clock cycles, worked out from the memory's nanosecond limits and the clock period. When the access is over it returns a one-cycle completion pulse, together with the read word for reads.

The memory's bidirectional data bus appears as three signals: a driven word, a driver enable and a sampled word. The driver enable is only raised while the memory has its own outputs floated. Two parameters set the timing. `CLK_NS` is the clock period in nanoseconds. `SLOW_GRADE` picks the 70 ns memory grade when set and the 55 ns grade when clear. Each limit becomes `ceil(limit / CLK_NS)` cycles.

The state machine has these states:
- `ST_IDLE`: deselected; a request is accepted here.
- `ST_READ`: access time.
- `ST_WR_TURN`: write strobe low with the data drivers still off.
- `ST_WR_DATA`: drivers on, data setup.
- `ST_WR_HOLD`: write strobe high, drivers still on.
- `ST_DONE`: deselected, completion pulse.

The transitions are:
- accept-read: `ST_IDLE` to `ST_READ`.
- accept-write: `ST_IDLE` to `ST_WR_TURN`.
- read-expire: `ST_READ` to `ST_DONE`.
- turn-expire: `ST_WR_TURN` to `ST_WR_DATA`.
- setup-expire: `ST_WR_DATA` to `ST_WR_HOLD`.
- hold-expire: `ST_WR_HOLD` to `ST_DONE`.
- finish: `ST_DONE` to `ST_IDLE`.

Top module: `sram_ctrl`

## Requirements
The cycle counts below are for the default parameters: a 10 ns clock and the 55 ns grade.
- R1: `req_ready` is high exactly when the controller is idle, and it is high after reset. A request is taken only when `req_valid` is high while `req_ready` is high. A `req_valid` pulse during a busy access has no effect on the memory contents, and it produces no completion.
- R2: A write drives `mem_ce_n` and `mem_we_n` low together, at the latched address. `mem_be_n[0]` is low when `req_be[0]` was 1, which stores bits 7:0. `mem_be_n[1]` is low when `req_be[1]` was 1, which stores bits 15:8. A lane whose enable bit is 0 keeps its old content.
- R3: During a write, `mem_we_n` stays low for 5 cycles. `mem_dq_oe` stays low for the first 2 of those cycles, which is the float gap. It is then high for the remaining 3 cycles of data setup, holding a stable word. It is still high in the single cycle after `mem_we_n` rises, and low after that.
- R4: `mem_oe_n` is high whenever `mem_we_n` is low. `mem_dq_oe` is never high while `mem_oe_n` is low.
- R5: A read holds `mem_ce_n` low, `mem_oe_n` low and `mem_we_n` high for 6 cycles. It samples `mem_dq_in` at the end of the last of those cycles.
- R6: In the returned read word, a lane whose `req_be` bit was 0 reads as zero. An enabled lane returns the stored byte.
- R7: `rsp_done` is a single-cycle pulse, one per accepted request. `rsp_rdata` holds the read word in that cycle.
- R8: `mem_ce_n` is high in the `rsp_done` cycle, so every access starts from a deselected memory.
- R9: `mem_addr` and `mem_be_n` are stable while `mem_ce_n` stays low. A write keeps `mem_ce_n` low for 6 cycles, which covers the write cycle time together with the deselect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables, bit 0 = bits 7:0 |
| req_ready | output | 1 | Idle, request can be taken |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read word, disabled lanes zero |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory lane enables, active low, bit 0 = lower |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Word to drive onto the data bus |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_in | input | 16 | Word sampled from the data bus |

## Verification
The bench's memory model returns junk until a read has been stable for the full access time. A controller that samples early therefore returns garbage. The model also returns junk on lanes whose enable is high, so a controller that does not zero disabled lanes leaks that junk into the read word.

Each write is timed at the pins. Drivers switched on inside the float gap, a write strobe that is too short, or too few data-setup cycles all show up as wrong counts. The same is true of a missing deselect cycle or of drivers enabled against a low output enable.

The bench also aims at specific data errors:
- Partial-lane writes, and a write with no lanes enabled, catch swapped or inverted lane enables, which corrupt neighbouring bytes.
- A request pulsed during a busy write catches a controller that accepts outside idle. Such a controller overwrites data and emits an extra completion.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_READ    = 3'd1,
        ST_WR_TURN = 3'd2,
        ST_WR_DATA = 3'd3,
        ST_WR_HOLD = 3'd4,
        ST_DONE    = 3'd5
    } ctrl_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] word_out
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_out[l*8 +: 8] <= '0;
            end else if (capture) begin
                word_out[l*8 +: 8] <= lane_en[l] ? bus_in[l*8 +: 8] : 8'h00;
            end
        end
    end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int CLK_NS     = 10,
    parameter bit SLOW_GRADE = 1'b0,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    localparam int LANES     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_be_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    // Memory limits in ns for the selected grade.
    localparam int T_ACC  = SLOW_GRADE ? 70 : 55;  // read access and cycle
    localparam int T_OEA  = SLOW_GRADE ? 35 : 25;  // output/lane enable access
    localparam int T_PWE  = SLOW_GRADE ? 50 : 40;  // write strobe width
    localparam int T_SEL  = SLOW_GRADE ? 60 : 40;  // select/addr/lane to write end
    localparam int T_DSU  = SLOW_GRADE ? 30 : 25;  // data setup to write end
    localparam int T_FLT  = SLOW_GRADE ? 25 : 20;  // memory output float time

    // Phase lengths in cycles.
    localparam int RD_CYC   = imax(ns_to_cyc(T_ACC, CLK_NS), ns_to_cyc(T_OEA, CLK_NS));
    localparam int TURN_CYC = ns_to_cyc(T_FLT, CLK_NS);
    localparam int DATA_CYC = imax(ns_to_cyc(T_DSU, CLK_NS),
                                   imax(ns_to_cyc(T_PWE, CLK_NS) - TURN_CYC,
                                        ns_to_cyc(T_SEL, CLK_NS) - TURN_CYC));
    localparam int HOLD_CYC = imax(1, ns_to_cyc(T_ACC, CLK_NS) - TURN_CYC - DATA_CYC - 1);
    localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(DATA_CYC, HOLD_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    ctrl_state_e        state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   be_q, be_next;
    logic               accept;
    logic               t_load, t_exp;
    logic [CNT_W-1:0]   t_val;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign be_next   = accept ? req_be : be_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  ((state_q == ST_READ) && t_exp),
        .lane_en  (be_q),
        .bus_in   (mem_dq_in),
        .word_out (rsp_rdata)
    );

    // Next state and phase timer loading.
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    t_load  = 1'b1;
                    state_d = req_write ? ST_WR_TURN : ST_READ;
                    t_val   = req_write ? CNT_W'(TURN_CYC - 1) : CNT_W'(RD_CYC - 1);
                end
            end
            ST_READ: begin
                if (t_exp) state_d = ST_DONE;
            end
            ST_WR_TURN: begin
                if (t_exp) begin
                    state_d = ST_WR_DATA;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(DATA_CYC - 1);
                end
            end
            ST_WR_DATA: begin
                if (t_exp) begin
                    state_d = ST_WR_HOLD;
                    t_load  = 1'b1;
                    t_val   = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WR_HOLD: begin
                if (t_exp) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latch.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
        end
    end

    // Registered memory strobes decoded from the next state: glitch-free pins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
            rsp_done  <= 1'b0;
        end else begin
            mem_ce_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_be_n  <= '1;
            mem_dq_oe <= 1'b0;
            rsp_done  <= 1'b0;
            unique case (state_d)
                ST_IDLE: ;
                ST_READ: begin
                    mem_ce_n <= 1'b0;
                    mem_oe_n <= 1'b0;
                    mem_be_n <= ~be_next;
                end
                ST_WR_TURN: begin
                    mem_ce_n <= 1'b0;
                    mem_we_n <= 1'b0;
                    mem_be_n <= ~be_next;
                end
                ST_WR_DATA: begin
                    mem_ce_n  <= 1'b0;
                    mem_we_n  <= 1'b0;
                    mem_be_n  <= ~be_next;
                    mem_dq_oe <= 1'b1;
                end
                ST_WR_HOLD: begin
                    mem_ce_n  <= 1'b0;
                    mem_be_n  <= ~be_next;
                    mem_dq_oe <= 1'b1;
                end
                ST_DONE: rsp_done <= 1'b1;
                default: ;
            endcase
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // ---------------- assertions ----------------
    assert_accept_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_we_with_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    assert_float_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    assert_drive_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_ce_n));

    assert_read_levels_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_deselect_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> mem_ce_n);

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_RD     = 6;  // R5
    localparam int EXP_WE     = 5;  // R3
    localparam int EXP_TURN   = 2;  // R3
    localparam int EXP_DRV    = 3;  // R3
    localparam int EXP_CE_WR  = 6;  // R9
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_done, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
    logic [1:0]  mem_be_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [15:0] store [int];
    logic [15:0] shadow [int];
    int          rd_cnt = 0;
    logic [15:0] rd_addr_last = '0;

    function automatic logic [15:0] get_word(input logic [15:0] a);
        return store.exists(int'(a)) ? store[int'(a)] : 16'h0000;
    endfunction

    always @* begin
        logic [15:0] w;
        w = get_word(mem_addr);
        mem_dq_in[7:0]  = (rd_cnt >= EXP_RD && !mem_be_n[0]) ? w[7:0]  : 8'hA5;
        mem_dq_in[15:8] = (rd_cnt >= EXP_RD && !mem_be_n[1]) ? w[15:8] : 8'h5A;
    end

    always @(negedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
            rd_cnt = (mem_addr == rd_addr_last && rd_cnt > 0) ? rd_cnt + 1 : 1;
            rd_addr_last = mem_addr;
        end else begin
            rd_cnt = 0;
        end
        if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
            logic [15:0] w;
            w = get_word(mem_addr);
            if (!mem_be_n[0]) w[7:0]  = mem_dq_out[7:0];
            if (!mem_be_n[1]) w[15:8] = mem_dq_out[15:8];
            store[int'(mem_addr)] = w;
        end
    end

    // ---------------- scoreboard ----------------
    logic [15:0] exp_data[$];
    bit          exp_isrd[$];
    string       exp_tag[$];
    bit          acc_wr = 1'b0;
    logic [1:0]  acc_be = '0;
    int          accepted = 0, dones = 0;

    task automatic do_req(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, input string tag);
        logic [15:0] old, e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        acc_wr = wr; acc_be = be;
        old = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        if (wr) begin
            if (be[0]) old[7:0]  = d[7:0];
            if (be[1]) old[15:8] = d[15:8];
            shadow[int'(a)] = old;
            e = 16'h0;
        end else begin
            e = {be[1] ? old[15:8] : 8'h00, be[0] ? old[7:0] : 8'h00};
        end
        exp_data.push_back(e); exp_isrd.push_back(!wr); exp_tag.push_back(tag);
        accepted++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // ---------------- pin monitor ----------------
    int   ce_cnt = 0, we_cnt = 0, drv_cnt = 0;
    bit   gap_bad = 0, cont_bad = 0, prev_ce = 1, prev_done = 0;
    logic [1:0] seen_be = '1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) begin
                ce_cnt++;
                if (!mem_we_n) begin
                    we_cnt++;
                    if (mem_dq_oe) drv_cnt++;
                    if (mem_dq_oe && we_cnt <= EXP_TURN) gap_bad = 1;
                    if (!mem_oe_n) cont_bad = 1;
                end
                seen_be = mem_be_n;
                if (mem_dq_oe && !mem_oe_n) cont_bad = 1;
            end else if (!prev_ce) begin
                if (acc_wr) begin
                    chk(ce_cnt == EXP_CE_WR, "R9", "write select cycles", ce_cnt, EXP_CE_WR);
                    chk(we_cnt == EXP_WE, "R3", "write strobe cycles", we_cnt, EXP_WE);
                    chk(drv_cnt == EXP_DRV, "R3", "data setup cycles", drv_cnt, EXP_DRV);
                    chk(!gap_bad, "R3", "drivers in float gap", gap_bad, 0);
                    chk(seen_be == ~acc_be, "R2", "write lane enables", seen_be, ~acc_be);
                end else begin
                    chk(ce_cnt == EXP_RD, "R5", "read access cycles", ce_cnt, EXP_RD);
                    chk(we_cnt == 0, "R5", "strobe during read", we_cnt, 0);
                end
                chk(!cont_bad, "R4", "bus contention", cont_bad, 0);
                ce_cnt = 0; we_cnt = 0; drv_cnt = 0; gap_bad = 0; cont_bad = 0;
            end
            prev_ce = mem_ce_n;
            if (rsp_done) begin
                dones++;
                chk(mem_ce_n, "R8", "deselected at done", mem_ce_n, 1);
                chk(!prev_done, "R7", "done width", prev_done, 0);
                if (exp_data.size() == 0) begin
                    chk(0, "R7", "unexpected done", 1, 0);
                end else begin
                    logic [15:0] e; bit isrd; string t;
                    e = exp_data.pop_front(); isrd = exp_isrd.pop_front(); t = exp_tag.pop_front();
                    if (isrd) chk(rsp_rdata == e, t, "read word", rsp_rdata, e);
                end
            end
            prev_done = rsp_done;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done} == 5'b11100,
            "R8", "pins after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_done}, 5'b11100);

        do_req(1, 16'h000A, 16'h1234, 2'b11, "R2");
        do_req(0, 16'h000A, 16'h0000, 2'b11, "R5");
        do_req(1, 16'h000A, 16'hABCD, 2'b01, "R2");   // lower lane only
        do_req(0, 16'h000A, 16'h0000, 2'b11, "R2");   // expect 12CD
        do_req(1, 16'h000A, 16'hEF00, 2'b10, "R2");   // upper lane only
        do_req(0, 16'h000A, 16'h0000, 2'b11, "R2");   // expect EFCD
        do_req(0, 16'h000A, 16'h0000, 2'b01, "R6");   // expect 00CD
        do_req(0, 16'h000A, 16'h0000, 2'b10, "R6");   // expect EF00
        do_req(0, 16'h000A, 16'h0000, 2'b00, "R6");   // expect 0000
        do_req(1, 16'h000A, 16'h7777, 2'b00, "R2");   // no lane enabled
        do_req(0, 16'h000A, 16'h0000, 2'b11, "R2");   // still EFCD

        for (int i = 0; i < 8; i++)
            do_req(1, 16'hFFF8 + 16'(i), 16'(i * 16'h1111) ^ 16'h0F0F, 2'b11, "R5");
        for (int i = 7; i >= 0; i--)
            do_req(0, 16'hFFF8 + 16'(i), 16'h0000, 2'b11, "R5");

        // R1: a request during a busy write is ignored
        do_req(1, 16'h0020, 16'h1111, 2'b11, "R1");
        @(negedge clk);
        chk(req_ready == 1'b0, "R1", "busy during write", req_ready, 0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0020; req_wdata = 16'h9999; req_be = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        do_req(0, 16'h0020, 16'h0000, 2'b11, "R1");

        repeat (12) @(negedge clk);
        chk(exp_data.size() == 0, "R7", "pending completions", exp_data.size(), 0);
        chk(dones == accepted, "R1", "completions per accept", dones, accepted);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        chk(0, "R7", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule